// File: doc/BRIEF.md
# Reloadable Timer PWM Generator

This block produces one pulse-width-modulated output from an up-counting timer. The counter climbs toward all-ones, one step per tick. When it passes all-ones it reloads from a period register. Two events flip a toggle flip-flop that drives the output. The first is that wrap (the overflow event). The second is the counter landing on the value held in a compare register (the match event). An optional power-of-two divider sits in front of the counter and slows the tick.

A host programs the block through a single-cycle write port. Writes that change timing (period, compare, counter, polarity, divider) are accepted only while the timer is halted. To reconfigure a running timer, the host halts it, rewrites the values and starts it again. Every start presets the counter to one below all-ones. The first overflow therefore arrives two ticks after the start and turns the output active.

The values to program follow from the wanted waveform. For a period of N ticks between overflows, the period register holds 2^32 − N. The compare register sits inside that window. The output is active for (compare − period value) ticks after each overflow and idle for the rest.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset, `pwm_out` is 0, `cnt_out` is 0, the timer is halted and polarity is non-inverted.
- R2: The timer starts when a control write (address 3) sets bit 0 while the timer is halted. That start loads the counter with 0xFFFFFFFE and clears the toggle. The first overflow comes two ticks later and flips the output to its active level.
- R3: While running, each tick increments the counter. A tick at 0xFFFFFFFF instead loads the period register (address 0) into the counter, and that is the overflow event.
- R4: The output flips on every overflow and on every tick that brings the counter to the compare register value (address 1). With period value L and compare value M, the active phase lasts M−L ticks and the idle phase lasts 2^32−M ticks.
- R5: When the compare value equals the period value, match events are suppressed and the output flips only on overflow, every 2^32−L ticks.
- R6: With control bit 2 set, one tick occurs every 2^(p+1) clocks, where p is control bits 5:3. With bit 2 clear, a tick occurs on every clock and p has no effect.
- R7: Control bit 1 inverts polarity. The idle level becomes 1 and the active level 0.
- R8: While running, writes to the period (0), compare (1) and counter (2) addresses have no effect. A control write has no effect on polarity or the divider, and a control write with bit 0 set does not restart the timer.
- R9: While halted, the counter holds its value except for counter writes (address 2), which load it directly. The output sits at the idle level (the value of control bit 1).
- R10: A control write with bit 0 clear halts a running timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | 0 period, 1 compare, 2 counter, 3 control |
| wr_data | input | 32 | Write data; control: bit0 run, bit1 invert, bit2 divider on, bits5:3 divider select |
| pwm_out | output | 1 | PWM output |
| cnt_out | output | 32 | Current counter value |

## Verification
The waveform is run with a short duty (compare close to the period value) and a long duty, which tells apart the two phase-length formulas. A run with compare equal to period value must give a square wave, which separates the suppression rule from an ordinary match. Runs with the divider on, and with a divider select but the divider off, tell a scaled tick from a plain one. One inverted run, in which illegal writes are issued mid-run, shows whether polarity flips the levels and whether the write guard holds.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
  // write-port addresses
  localparam logic [1:0] RPWM_A_LOAD  = 2'd0;
  localparam logic [1:0] RPWM_A_MATCH = 2'd1;
  localparam logic [1:0] RPWM_A_COUNT = 2'd2;
  localparam logic [1:0] RPWM_A_CTRL  = 2'd3;

  // control word bit positions
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_INV     = 1;
  localparam int CTRL_PSC_EN  = 2;
  localparam int CTRL_PSC_LSB = 3;
endpackage

// File: rtl/rpwm_regs.sv
module rpwm_regs #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] match_q,
  output logic             run_q,
  output logic             inv_q,
  output logic             psc_en_q,
  output logic [PSC_W-1:0] psc_sel_q,
  output logic             start_pls,
  output logic             stop_pls,
  output logic             cnt_wr
);
  import rpwm_pkg::*;

  logic wr_ctrl;
  logic wr_idle;

  assign wr_ctrl   = wr_en && (wr_addr == RPWM_A_CTRL);
  assign wr_idle   = wr_en && !run_q;
  assign start_pls = wr_ctrl && !run_q && wr_data[CTRL_RUN];
  assign stop_pls  = wr_ctrl && run_q && !wr_data[CTRL_RUN];
  assign cnt_wr    = wr_idle && (wr_addr == RPWM_A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= '0;
      match_q   <= '0;
      run_q     <= 1'b0;
      inv_q     <= 1'b0;
      psc_en_q  <= 1'b0;
      psc_sel_q <= '0;
    end else if (wr_idle) begin
      case (wr_addr)
        RPWM_A_LOAD:  load_q  <= wr_data;
        RPWM_A_MATCH: match_q <= wr_data;
        RPWM_A_CTRL: begin
          run_q     <= wr_data[CTRL_RUN];
          inv_q     <= wr_data[CTRL_INV];
          psc_en_q  <= wr_data[CTRL_PSC_EN];
          psc_sel_q <= wr_data[CTRL_PSC_LSB +: PSC_W];
        end
        default: ;
      endcase
    end else if (stop_pls) begin
      run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpwm_prescale.sv
module rpwm_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 1 << PSC_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low (sel+1) bits set: the divider wraps every 2^(sel+1) clocks
  function automatic logic [DIV_W-1:0] ratio_mask(input logic [PSC_W-1:0] s);
    logic [DIV_W-1:0] m;
    for (int i = 0; i < DIV_W; i++) m[i] = (i <= int'(s));
    return m;
  endfunction

  assign mask = ratio_mask(sel);
  assign tick = run && (!en || ((div_q & mask) == mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/rpwm_counter.sv
module rpwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] load,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] PRESET = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] ld);
    return (&c) ? ld : c + 1'b1;
  endfunction

  assign cnt_nxt   = step(cnt_q, load);
  assign ovf_evt   = tick && (&cnt_q);
  assign match_evt = tick && (cnt_nxt == match) && (match != load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= PRESET;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (tick)   cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rpwm_outstage.sv
module rpwm_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  input  logic inv,
  input  logic ovf_evt,
  input  logic match_evt,
  output logic pwm_out
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tog_q <= 1'b0;
    else if (start || !run)        tog_q <= 1'b0;
    else if (ovf_evt || match_evt) tog_q <= !tog_q;
  end

  assign pwm_out = run ? (tog_q ^ inv) : inv;
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic [CNT_W-1:0] cnt_out
);
  logic [CNT_W-1:0] load_q, match_q, cnt_q;
  logic             run_q, inv_q, psc_en_q;
  logic [PSC_W-1:0] psc_sel_q;
  logic             start_pls, stop_pls, cnt_wr;
  logic             tick, ovf_evt, match_evt;

  rpwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_q(load_q), .match_q(match_q), .run_q(run_q), .inv_q(inv_q),
    .psc_en_q(psc_en_q), .psc_sel_q(psc_sel_q),
    .start_pls(start_pls), .stop_pls(stop_pls), .cnt_wr(cnt_wr)
  );

  rpwm_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .en(psc_en_q), .sel(psc_sel_q), .tick(tick)
  );

  rpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_pls), .cnt_wr(cnt_wr),
    .cnt_wdata(wr_data), .load(load_q), .match(match_q),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  rpwm_outstage u_out (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(start_pls), .inv(inv_q),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .pwm_out(pwm_out)
  );

  assign cnt_out = cnt_q;
endmodule

// File: rtl/rpwm_checker.sv
module rpwm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             inv_q,
  input logic             start_pls,
  input logic             stop_pls,
  input logic             cnt_wr,
  input logic             tick,
  input logic             ovf_evt,
  input logic             match_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             pwm_out
);
  localparam logic [CNT_W-1:0] PRESET = {{(CNT_W-1){1'b1}}, 1'b0};

  // R2
  start_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cnt_q == PRESET);

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_q == $past(load_q));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf_evt) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R4
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && match_evt));

  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !stop_pls && (ovf_evt || match_evt)) |=> pwm_out != $past(pwm_out));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_pls && !cnt_wr) |=> $stable(cnt_q));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> pwm_out == inv_q);

  // R6
  no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);
endmodule

bind reload_pwm_timer rpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .inv_q(inv_q), .start_pls(start_pls),
  .stop_pls(stop_pls), .cnt_wr(cnt_wr), .tick(tick), .ovf_evt(ovf_evt),
  .match_evt(match_evt), .cnt_q(cnt_q), .load_q(load_q), .pwm_out(pwm_out)
);

// File: tb/tb_reload_pwm_timer.sv
module tb_reload_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic        pwm_out;
  logic [31:0] cnt_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  typedef struct { bit lvl; int len; string req; } seg_t;
  seg_t exp_q[$];

  bit arm = 1'b0;
  bit mon_lvl;
  int mon_len;

  reload_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .cnt_out(cnt_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  // monitor: measure run lengths of pwm_out, compare with scoreboard
  always @(negedge clk) begin
    if (arm) begin
      if (pwm_out == mon_lvl) mon_len++;
      else begin
        if (exp_q.size() > 0) begin
          seg_t e;
          e = exp_q.pop_front();
          check(mon_lvl == e.lvl, {e.req, " level"}, mon_lvl, e.lvl);
          check(mon_len == e.len, {e.req, " length"}, mon_len, e.len);
        end
        mon_lvl = pwm_out;
        mon_len = 1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit run, input bit inv, input bit pe, input int p);
    return {26'd0, p[2:0], pe, inv, run};
  endfunction

  // driver: configure, push expected segments, start, wait, halt
  task automatic run_case(input logic [31:0] ld, input logic [31:0] mt, input bit pe,
                          input int p, input bit inv, input int nseg, input bit poke,
                          input string req);
    int r;
    longint per, hi, lo;
    int guard;
    r   = pe ? (1 << (p + 1)) : 1;
    per = 64'h1_0000_0000 - longint'(ld);
    hi  = longint'(mt) - longint'(ld);
    lo  = 64'h1_0000_0000 - longint'(mt);
    wr(2'd0, ld);
    wr(2'd1, mt);
    wr(2'd3, ctrl(0, inv, pe, p));
    exp_q.push_back('{inv, 2 * r, "R2 first"});
    for (int k = 1; k <= nseg; k++) begin
      bit active = (k % 2) == 1;
      int len;
      if (ld == mt) len = int'(per) * r;
      else          len = active ? int'(hi) * r : int'(lo) * r;
      exp_q.push_back('{active ? !inv : inv, len, req});
    end
    wr(2'd3, ctrl(1, inv, pe, p));
    mon_lvl = inv; mon_len = 0; arm = 1'b1;
    check(cnt_out == 32'hFFFF_FFFE, "R2 preset", cnt_out, 32'hFFFF_FFFE);
    if (poke) begin
      // R8: timing writes and a second start while running have no effect
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h0000_0005);
      wr(2'd3, ctrl(1, !inv, 1'b1, 7));
    end
    guard = 0;
    while (exp_q.size() > 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    check(exp_q.size() == 0, {req, " segments seen"}, exp_q.size(), 0);
    exp_q.delete();
    arm = 1'b0;
    // R10 halt, R9 idle level
    wr(2'd3, ctrl(0, inv, pe, p));
    check(pwm_out == inv, "R9 idle level after halt", pwm_out, inv);
  endtask

  initial begin
    logic [31:0] snap;
    #45 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(cnt_out == 32'd0, "R1 cnt_out", cnt_out, 0);

    // R9 counter write while halted, then hold
    wr(2'd2, 32'h1234_5678);
    check(cnt_out == 32'h1234_5678, "R9 counter write", cnt_out, 32'h1234_5678);
    repeat (5) @(negedge clk);
    check(cnt_out == 32'h1234_5678, "R9 counter hold", cnt_out, 32'h1234_5678);

    // R3/R4 short duty: period 22, active 5, idle 17
    run_case(32'hFFFF_FFEA, 32'hFFFF_FFEF, 1'b0, 0, 1'b0, 5, 1'b0, "R4 short duty");
    // R4 long duty, R7 inverted, R8 writes during run
    run_case(32'hFFFF_FFEA, 32'hFFFF_FFF9, 1'b0, 0, 1'b1, 5, 1'b1, "R7 inverted long duty");
    // R5 compare equals period value: square wave of 10
    run_case(32'hFFFF_FFF6, 32'hFFFF_FFF6, 1'b0, 0, 1'b0, 4, 1'b0, "R5 compare disabled");
    // R6 divider on, ratio 4
    run_case(32'hFFFF_FFF0, 32'hFFFF_FFF3, 1'b1, 1, 1'b0, 4, 1'b0, "R6 divide by 4");
    // R6 divider select set but divider off: plain tick
    run_case(32'hFFFF_FFF0, 32'hFFFF_FFF3, 1'b0, 5, 1'b0, 4, 1'b0, "R6 divider off");

    // R9 counter holds after halt
    snap = cnt_out;
    repeat (6) @(negedge clk);
    check(cnt_out == snap, "R9 hold after halt", cnt_out, snap);

    finish_run();
  end
endmodule